// File: doc/BRIEF.md
# Triangle LFO Amplitude and Phase Stepper

This block is a low-frequency oscillator for an FM voice. A 32-bit phase accumulator holds 7 integer bits above 25 fraction bits. On every clock in which the oscillator runs, the per-sample frequency increment is added to the accumulator. The 7-bit integer part, called the step, drives two outputs. The first is an amplitude-modulation depth: a triangle that rises over the lower half of the step range, falls back over the upper half, and is stored doubled. The second is a phase-modulation index, which is the step divided by four. Both registers are rewritten only on a cycle in which the value they depend on actually moves.

The depth is added to each operator's envelope attenuation. The amount added is the depth shifted right by a 2-bit sensitivity code. It reaches only those operators whose mask bit is set, and only while the oscillator runs.

A two-state controller follows the enable input one clock late. In `ST_HOLD` the accumulator and both registers keep their values and no operator receives amplitude modulation. In `ST_RUN` the accumulator advances and modulation is applied. The transition START (`ST_HOLD` to `ST_RUN`) happens at the first clock edge that samples the enable high. The transition STOP (`ST_RUN` to `ST_HOLD`) happens at the first clock edge that samples it low. Clocks are one per output sample.

Top module: `lfo_am_pm_stepper`

## Requirements
- R1: After reset the controller is in `ST_HOLD`, the accumulator is 0, `am_depth` is 0, `pm_idx` is 0, and every `env_out` slice equals its `env_in` slice.
- R2: In `ST_RUN` the accumulator adds `freq_inc` modulo 2^32 at every clock edge. The step is accumulator bits [31:25], so the step wraps from 127 to 0, and an increment of 0xFFFFFFFF walks the step downward.
- R3: In `ST_HOLD` the accumulator, `am_depth` and `pm_idx` do not change, whatever `freq_inc` is.
- R4: For a step below 64, `am_depth` equals 2 × (step mod 64).
- R5: For a step of 64 or more, `am_depth` equals 2 × (63 − (step mod 64)), so the step pattern folds into a triangle with a peak of 126.
- R6: `pm_idx` equals the step shifted right by 2 (5 bits). It changes only at a clock edge in `ST_RUN`.
- R7: In `ST_RUN`, for an operator whose mask bit is 1, `env_out` equals `env_in` + (`am_depth` >> `am_sens`), for sensitivity codes 0 to 3.
- R8: An operator whose `am_mask` bit is 0 gets `env_out` equal to `env_in` in every state.
- R9: In `ST_HOLD` no operator receives modulation: every `env_out` slice equals its `env_in` slice.
- R10: The controller moves to `ST_RUN` at the clock edge that samples `lfo_en` high, and to `ST_HOLD` at the edge that samples it low. The accumulator therefore first advances at the edge after the enable is seen, and modulation stops one clock after the enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfo_en | input | 1 | Oscillator enable |
| freq_inc | input | 32 | Accumulator increment per sample |
| am_sens | input | 2 | Right-shift code applied to the depth before it is added |
| am_mask | input | NOPS (4) | Per-operator modulation enable, bit i for operator i |
| env_in | input | NOPS*EW (40) | Envelope attenuation per operator, operator i in bits [i*EW +: EW] |
| am_depth | output | 8 | Doubled triangle depth |
| pm_idx | output | 5 | Phase-modulation index |
| env_out | output | NOPS*(EW+1) (44) | Modulated attenuation, operator i in bits [i*(EW+1) +: EW+1] |

## Verification
A corrupted accumulator or step register cannot be seen directly at the ports. It shows up as a wrong `am_depth` or `pm_idx` at the first edge where the step moves: at the very next clock with a one-step increment, and only after many clocks with a small increment. An enable-latency error shows within one clock of an enable change, as an accumulator advance or modulation that arrives one cycle too early or too late. Errors in the fold point, the shift or the mask show at once on `env_out` for the affected operator, so every cycle is compared against a behavioural model.

// File: rtl/lfo_stepper_pkg.sv
package lfo_stepper_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } lfo_state_e;
endpackage

// File: rtl/lfo_phase_accum.sv
module lfo_phase_accum #(
    parameter int AW   = 32,
    parameter int FRAC = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic [AW-1:0]        inc,
    output logic [AW-FRAC:0]     am_depth,
    output logic [AW-FRAC-3:0]   pm_idx
);
    localparam int STEP_W = AW - FRAC;
    localparam int PM_W   = STEP_W - 2;
    localparam int PEAK   = 2 * ((1 << (STEP_W - 1)) - 1);

    logic [AW-1:0]       acc_q;
    logic [AW-1:0]       acc_nx;
    logic [STEP_W-1:0]   step_old;
    logic [STEP_W-1:0]   step_new;
    logic [STEP_W-2:0]   folded;

    always_comb begin
        acc_nx   = acc_q + inc;
        step_old = acc_q[AW-1:FRAC];
        step_new = acc_nx[AW-1:FRAC];
        folded   = step_new[STEP_W-1] ? ~step_new[STEP_W-2:0] : step_new[STEP_W-2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            am_depth <= '0;
            pm_idx   <= '0;
        end else if (advance) begin
            acc_q <= acc_nx;
            if (step_new != step_old)
                am_depth <= {1'b0, folded, 1'b0};
            if (step_new[STEP_W-1:2] != step_old[STEP_W-1:2])
                pm_idx <= step_new[STEP_W-1:2];
        end
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(am_depth) && $stable(pm_idx)));
    // R4
    am_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        am_depth[0] == 1'b0);
    // R5
    am_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        am_depth <= (STEP_W+1)'(PEAK));
    // R6
    pm_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pm_idx) |-> $past(advance));

    logic [PM_W-1:0] unused_pm_w;
    assign unused_pm_w = '0;
endmodule

// File: rtl/lfo_am_apply.sv
module lfo_am_apply #(
    parameter int EW  = 10,
    parameter int AMW = 8
) (
    input  logic [EW-1:0]  env_in,
    input  logic [AMW-1:0] am_depth,
    input  logic [1:0]     sens,
    input  logic           apply,
    output logic [EW:0]    env_out
);
    logic [AMW-1:0] add_w;

    always_comb begin
        add_w   = apply ? (am_depth >> sens) : '0;
        env_out = (EW+1)'(env_in) + (EW+1)'(add_w);
    end

    // R7
    always_comb begin
        add_bound_chk: assert (env_out - (EW+1)'(env_in) <= (EW+1)'(am_depth));
    end
endmodule

// File: rtl/lfo_am_pm_stepper.sv
module lfo_am_pm_stepper
    import lfo_stepper_pkg::*;
#(
    parameter int AW   = 32,
    parameter int FRAC = 25,
    parameter int NOPS = 4,
    parameter int EW   = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lfo_en,
    input  logic [AW-1:0]          freq_inc,
    input  logic [1:0]             am_sens,
    input  logic [NOPS-1:0]        am_mask,
    input  logic [NOPS*EW-1:0]     env_in,
    output logic [AW-FRAC:0]       am_depth,
    output logic [AW-FRAC-3:0]     pm_idx,
    output logic [NOPS*(EW+1)-1:0] env_out
);
    localparam int AMW = AW - FRAC + 1;

    lfo_state_e state_q;
    lfo_state_e state_nx;
    logic       running;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HOLD: if (lfo_en)  state_nx = ST_RUN;
            ST_RUN:  if (!lfo_en) state_nx = ST_HOLD;
            default: state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_nx;
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

    lfo_phase_accum #(.AW(AW), .FRAC(FRAC)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (running),
        .inc      (freq_inc),
        .am_depth (am_depth),
        .pm_idx   (pm_idx)
    );

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        lfo_am_apply #(.EW(EW), .AMW(AMW)) u_apply (
            .env_in   (env_in[i*EW +: EW]),
            .am_depth (am_depth),
            .sens     (am_sens),
            .apply    (running && am_mask[i]),
            .env_out  (env_out[i*(EW+1) +: EW+1])
        );

        // R8
        mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !am_mask[i] |-> env_out[i*(EW+1) +: EW+1] == (EW+1)'(env_in[i*EW +: EW]));
        // R9
        hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!lfo_en) |-> env_out[i*(EW+1) +: EW+1] == (EW+1)'(env_in[i*EW +: EW]));
    end

    // R10
    start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lfo_en && !running) |=> ($stable(am_depth) && $stable(pm_idx)));
endmodule

// File: tb/lfo_am_pm_stepper_tb.sv
module lfo_am_pm_stepper_tb;
    localparam int NOPS = 4;
    localparam int EW   = 10;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   lfo_en = 1'b0;
    logic [31:0]            freq_inc = '0;
    logic [1:0]             am_sens = '0;
    logic [NOPS-1:0]        am_mask = '0;
    logic [NOPS*EW-1:0]     env_in = '0;
    logic [7:0]             am_depth;
    logic [4:0]             pm_idx;
    logic [NOPS*(EW+1)-1:0] env_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    bit    done     = 0;
    string ph       = "R1";

    bit          ref_run = 0;
    bit [31:0]   ref_cnt = 0;

    always #5 clk = ~clk;

    lfo_am_pm_stepper u_dut (
        .clk(clk), .rst_n(rst_n), .lfo_en(lfo_en), .freq_inc(freq_inc),
        .am_sens(am_sens), .am_mask(am_mask), .env_in(env_in),
        .am_depth(am_depth), .pm_idx(pm_idx), .env_out(env_out)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_run = 0;
            ref_cnt = 0;
        end else begin
            if (ref_run) ref_cnt = ref_cnt + freq_inc;
            ref_run = lfo_en;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s %s: actual %0d expected %0d", ph, tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int step, exp_am, exp_env, ein;
        string tag;
        step   = int'(ref_cnt >> 25);
        exp_am = (step < 64) ? 2 * (step % 64) : 2 * (63 - (step % 64));
        check((step < 64) ? "R4" : "R5", "am_depth", int'(am_depth), exp_am);
        check("R6", "pm_idx", int'(pm_idx), step / 4);
        for (int i = 0; i < NOPS; i++) begin
            ein     = int'(env_in[i*EW +: EW]);
            exp_env = ein + ((ref_run && am_mask[i]) ? (exp_am >> am_sens) : 0);
            tag     = !ref_run ? "R9" : (!am_mask[i] ? "R8" : "R7");
            check(tag, "env_out", int'(env_out[i*(EW+1) +: EW+1]), exp_env);
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc++;
            compare_all();
            for (int i = 0; i < NOPS; i++)
                env_in[i*EW +: EW] = EW'((cyc * 37 + i * 211) % 1024);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        ph = "R1";
        am_mask = 4'hF;
        run(3);
        rst_n = 1'b1;
        run(2);

        // R10 start latency, one step per clock through rise, fold and wrap (R2)
        ph = "R10";
        freq_inc = 32'h0200_0000;
        lfo_en = 1'b1;
        run(3);
        ph = "R2";
        run(140);

        // R7 sensitivity sweep with all operators enabled
        ph = "R7";
        for (int s = 0; s < 4; s++) begin
            am_sens = 2'(s);
            run(20);
        end

        // R8 mask patterns
        ph = "R8";
        am_sens = 2'd1;
        am_mask = 4'b0101; run(15);
        am_mask = 4'b1010; run(15);
        am_mask = 4'b0000; run(10);
        am_mask = 4'b1111;

        // R3 and R9 hold while disabled, increment still applied at the input
        ph = "R3";
        lfo_en = 1'b0;
        freq_inc = 32'h0600_0000;
        run(12);
        ph = "R10";
        lfo_en = 1'b1;
        run(4);

        // R2 downward walk through wrap
        ph = "R2";
        freq_inc = 32'hFFFF_FFFF;
        run(5);
        freq_inc = 32'hFE00_0000;
        run(140);

        // slow increment: step moves only every few clocks
        ph = "R6";
        freq_inc = 32'h0040_0000;
        run(100);

        // large increment
        freq_inc = 32'h3A00_1234;
        am_sens = 2'd0;
        run(60);

        // STOP mid-run and reset again
        ph = "R9";
        lfo_en = 1'b0;
        run(6);
        ph = "R1";
        rst_n = 1'b0;
        run(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule